// File: doc/BRIEF.md
# Expansion Chassis Bus Adapter

This block sits on a byte-wide peripheral bus as a slave and gives the host a path into an older expansion chassis that has a 21-bit address space and a 16-bit data path. The host sees four byte ports, selected by a 2-bit port number. The host loads the chassis address with three byte writes into one port. It moves data through a port for the even (high) byte and a port for the odd (low) byte. A small internal state machine drives the chassis memory-enable, write-enable and data-in-direction strobes. It stalls the host through a wait output for as long as the chassis holds READY low.

A write to the odd-byte port starts a 16-bit chassis write. A read of the even-byte port starts a 16-bit chassis read, and both returned bytes are kept. A later read of the odd-byte port is answered from that stored copy. After every chassis transfer the address steps forward by one word, so the host can stream a block without reloading the address. Host strobes are single-cycle pulses that count only while the select input is high.

The cycle state machine has four states. CY_IDLE waits for an accepted start. CY_SETUP presents the address and memory-enable for one cycle. CY_STROBE drives the write or read strobe and stays there while READY is low. CY_DONE closes the transfer and advances the address. The transitions are: start (CY_IDLE to CY_SETUP), launch (CY_SETUP to CY_STROBE), hold (CY_STROBE to itself while READY is low), complete (CY_STROBE to CY_DONE when READY is high), and retire (CY_DONE to CY_IDLE).

Top module: `xbus_adapter`

## Requirements
- R1: After reset, wait_o, ch_ena, ch_mem_en, ch_we and ch_dbin are low, ch_addr is zero and rdata reads zero on every port.
- R2: A write to port 0 loads one address byte, most significant first. The first byte fills ch_addr[20:16] from wdata[4:0] and ignores wdata[7:5]. The second fills ch_addr[15:8] and the third fills ch_addr[7:0].
- R3: The address byte counter returns to the first position after the third port 0 write. Any accepted access to port 1, read or write, returns it to the first position.
- R4: A write to port 2 only stores the even byte and starts no chassis cycle. A write to port 3 starts one chassis write of ch_dout = {even byte, written odd byte}, with the even byte in bits [15:8].
- R5: A read of port 2 starts one chassis read and returns ch_din[15:8]. A following read of port 3 returns the ch_din[7:0] captured by that same chassis read and starts no cycle.
- R6: wait_o rises on the cycle after an accepted start and lasts 3 cycles when READY is high. It is extended by each cycle that READY is low while the strobe is driven.
- R7: ch_ena is high exactly while a chassis cycle is in progress, which is the same interval in which wait_o is high.
- R8: Each completed chassis transfer advances ch_addr by 2, wrapping modulo 2^21. ch_addr holds steady while memory-enable is active.
- R9: Strobes are ignored when sel is low or while a chassis cycle is in progress.
- R10: ch_mem_en is high during setup and strobe. ch_we is high only during the strobe of a write and only together with ch_mem_en. ch_dbin is high during setup and strobe of a read. ch_we and ch_dbin are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Adapter selected on the peripheral bus |
| rd_stb | input | 1 | Host read strobe, one-cycle pulse |
| wr_stb | input | 1 | Host write strobe, one-cycle pulse |
| port | input | 2 | Port number: 0 address, 1 counter reset, 2 even byte, 3 odd byte |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte for the selected port |
| wait_o | output | 1 | Host stall while a chassis cycle runs |
| ch_addr | output | 21 | Chassis word address |
| ch_dout | output | 16 | Chassis write data |
| ch_din | input | 16 | Chassis read data |
| ch_ready | input | 1 | Chassis READY |
| ch_mem_en | output | 1 | Chassis memory enable |
| ch_we | output | 1 | Chassis write enable |
| ch_dbin | output | 1 | Chassis data-in direction (read) |
| ch_ena | output | 1 | External-access enable |

## Verification
On every cycle, the assertions check the strobe relations (R10), that the access enable and the wait output coincide (R7), that a write strobe holds while READY is low, that the host is not stalled by unselected strobes, and the word step and address stability of R8. Only the bench scenarios can show the byte order and counter behaviour of the address loads, the pairing of even and odd bytes on writes, the reuse of the captured odd byte on reads, and the exact length of the stall for each READY delay in the sweep.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        CY_IDLE   = 2'd0,
        CY_SETUP  = 2'd1,
        CY_STROBE = 2'd2,
        CY_DONE   = 2'd3
    } cyc_state_t;

    localparam logic [1:0] PORT_ADDR = 2'd0;
    localparam logic [1:0] PORT_RST  = 2'd1;
    localparam logic [1:0] PORT_EVEN = 2'd2;
    localparam logic [1:0] PORT_ODD  = 2'd3;
endpackage

// File: rtl/xbus_addr_reg.sv
module xbus_addr_reg #(
    parameter int AW   = 21,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [7:0]    load_byte,
    input  logic          cnt_clr,
    input  logic          step_en,
    output logic [AW-1:0] addr
);
    localparam int NB = (AW + 7) / 8;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;

    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            if (cnt_clr) begin
                cnt_q <= '0;
            end else if (load_en) begin
                for (int b = 0; b < AW; b++) begin
                    if ((b / 8) == (NB - 1 - int'(cnt_q))) begin
                        addr_q[b] <= load_byte[b % 8];
                    end
                end
                cnt_q <= (cnt_q == CW'(NB - 1)) ? '0 : cnt_q + 1'b1;
            end
            if (step_en) begin
                addr_q <= addr_q + AW'(STEP);
            end
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
    import xbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_write,
    input  logic ready,
    output logic busy,
    output logic mem_en,
    output logic we,
    output logic dbin,
    output logic capture,
    output logic step
);
    cyc_state_t state_q, state_d;
    logic       wr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CY_IDLE:   if (start) state_d = CY_SETUP;
            CY_SETUP:  state_d = CY_STROBE;
            CY_STROBE: if (ready) state_d = CY_DONE;
            CY_DONE:   state_d = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CY_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == CY_IDLE && start) begin
                wr_q <= start_write;
            end
        end
    end

    always_comb begin
        busy    = 1'b0;
        mem_en  = 1'b0;
        we      = 1'b0;
        dbin    = 1'b0;
        capture = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            CY_IDLE: ;
            CY_SETUP: begin
                busy   = 1'b1;
                mem_en = 1'b1;
                dbin   = !wr_q;
            end
            CY_STROBE: begin
                busy    = 1'b1;
                mem_en  = 1'b1;
                we      = wr_q;
                dbin    = !wr_q;
                capture = ready && !wr_q;
            end
            CY_DONE: begin
                busy = 1'b1;
                step = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xbus_adapter.sv
module xbus_adapter
    import xbus_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [1:0]    port,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          wait_o,
    output logic [AW-1:0] ch_addr,
    output logic [DW-1:0] ch_dout,
    input  logic [DW-1:0] ch_din,
    input  logic          ch_ready,
    output logic          ch_mem_en,
    output logic          ch_we,
    output logic          ch_dbin,
    output logic          ch_ena
);
    localparam int HB = DW / 2;

    logic          busy;
    logic          accept;
    logic          start_wr;
    logic          start_rd;
    logic          capture;
    logic          step;
    logic [HB-1:0] even_q;
    logic [DW-1:0] wr_data_q;
    logic [DW-1:0] rd_data_q;

    assign accept   = sel && (rd_stb || wr_stb) && !busy;
    assign start_wr = accept && wr_stb && (port == PORT_ODD);
    assign start_rd = accept && rd_stb && (port == PORT_EVEN);

    xbus_addr_reg #(.AW(AW), .STEP(2)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept && wr_stb && (port == PORT_ADDR)),
        .load_byte (wdata),
        .cnt_clr   (accept && (port == PORT_RST)),
        .step_en   (step),
        .addr      (ch_addr)
    );

    xbus_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_wr || start_rd),
        .start_write (start_wr),
        .ready       (ch_ready),
        .busy        (busy),
        .mem_en      (ch_mem_en),
        .we          (ch_we),
        .dbin        (ch_dbin),
        .capture     (capture),
        .step        (step)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_q    <= '0;
            wr_data_q <= '0;
            rd_data_q <= '0;
        end else begin
            if (accept && wr_stb && port == PORT_EVEN) begin
                even_q <= wdata[HB-1:0];
            end
            if (start_wr) begin
                wr_data_q <= {even_q, wdata[HB-1:0]};
            end
            if (capture) begin
                rd_data_q <= ch_din;
            end
        end
    end

    always_comb begin
        unique case (port)
            PORT_EVEN: rdata = rd_data_q[DW-1:HB];
            PORT_ODD:  rdata = rd_data_q[HB-1:0];
            default:   rdata = 8'h00;
        endcase
    end

    assign ch_dout = wr_data_q;
    assign wait_o  = busy;
    assign ch_ena  = busy;
endmodule

// File: rtl/xbus_adapter_checks.sv
module xbus_adapter_checks #(
    parameter int AW = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          wait_o,
    input logic          ch_ena,
    input logic          ch_mem_en,
    input logic          ch_we,
    input logic          ch_dbin,
    input logic          ch_ready,
    input logic [AW-1:0] ch_addr
);
    p_we_dbin_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_we && ch_dbin));

    p_we_in_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ch_we |-> ch_mem_en);

    p_ena_is_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_ena == wait_o);

    p_hold_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_we && !ch_ready) |=> ch_we);

    p_mem_needs_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_mem_en |-> wait_o);

    p_addr_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mem_en && $past(ch_mem_en)) |-> $stable(ch_addr));

    p_step_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_o) |-> ch_addr == AW'($past(ch_addr) + 2));

    p_unselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !wait_o) |=> !wait_o);
endmodule

bind xbus_adapter xbus_adapter_checks #(.AW(AW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wait_o    (wait_o),
    .ch_ena    (ch_ena),
    .ch_mem_en (ch_mem_en),
    .ch_we     (ch_we),
    .ch_dbin   (ch_dbin),
    .ch_ready  (ch_ready),
    .ch_addr   (ch_addr)
);

// File: tb/xbus_adapter_bench.sv
module xbus_adapter_bench;
    localparam int AW = 21;
    localparam logic [AW-1:0] AMASK = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [1:0]  port = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        wait_o;
    logic [20:0] ch_addr;
    logic [15:0] ch_dout;
    logic [15:0] ch_din;
    logic        ch_ready;
    logic        ch_mem_en;
    logic        ch_we;
    logic        ch_dbin;
    logic        ch_ena;

    int errors = 0;
    int checks = 0;
    int stall_cfg = 0;
    int scnt = 0;
    int cyc_n = 0;
    int viol = 0;
    int wcnt = 0;
    logic        mem_prev = 1'b0;
    logic [20:0] cap_addr = '0;
    logic [15:0] cap_data = '0;

    always #4 clk = ~clk;

    xbus_adapter u_xbus_adapter (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .port(port), .wdata(wdata), .rdata(rdata), .wait_o(wait_o),
        .ch_addr(ch_addr), .ch_dout(ch_dout), .ch_din(ch_din), .ch_ready(ch_ready),
        .ch_mem_en(ch_mem_en), .ch_we(ch_we), .ch_dbin(ch_dbin), .ch_ena(ch_ena)
    );

    function automatic logic [15:0] chassis_word(input logic [20:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + {3'b000, a[20:16]}};
    endfunction

    assign ch_din   = chassis_word(ch_addr);
    assign ch_ready = (scnt == 0);

    always @(posedge clk) begin
        if (!ch_mem_en) scnt <= stall_cfg;
        else if (scnt != 0) scnt <= scnt - 1;
        mem_prev <= ch_mem_en;
        if (ch_mem_en && !mem_prev) cyc_n <= cyc_n + 1;
        if (ch_we && ch_ready) begin
            cap_addr <= ch_addr;
            cap_data <= ch_dout;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (ch_ena != wait_o) viol <= viol + 1;
            if (ch_we && ch_dbin) viol <= viol + 1;
            if (ch_we && !ch_mem_en) viol <= viol + 1;
        end
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hacc(input bit rd, input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd_stb = rd; wr_stb = !rd; port = p; wdata = d;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        wcnt = 0;
        while (wait_o) begin
            wcnt++;
            @(negedge clk);
        end
    endtask

    task automatic set_addr(input logic [20:0] a);
        hacc(1'b1, 2'd1, 8'h00);
        hacc(1'b0, 2'd0, {3'b101, a[20:16]});
        hacc(1'b0, 2'd0, a[15:8]);
        hacc(1'b0, 2'd0, a[7:0]);
    endtask

    initial begin
        logic [20:0] a;
        int c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!wait_o && !ch_ena, "R1 wait/ena", {wait_o, ch_ena}, 0);
        check(!ch_mem_en && !ch_we && !ch_dbin, "R1 strobes", {ch_mem_en, ch_we, ch_dbin}, 0);
        check(ch_addr == 0, "R1 addr", ch_addr, 0);
        port = 2'd2;
        #1;
        check(rdata == 0, "R1 rdata", rdata, 0);
        rst_n = 1'b1;

        // R2 address load sweep
        for (int i = 0; i < 12; i++) begin
            a = (i == 11) ? 21'h1FFFFF : 21'((i * 32'h2A5F3 + 32'h13) & 32'h1FFFFF);
            set_addr(a);
            check(ch_addr == a, "R2 addr load", ch_addr, a);
        end

        // R3 counter cleared by port 1 mid-load, and wrap after third byte
        hacc(1'b0, 2'd0, 8'h1C);
        hacc(1'b0, 2'd0, 8'h77);
        hacc(1'b0, 2'd1, 8'h00);
        hacc(1'b0, 2'd0, 8'h03);
        hacc(1'b0, 2'd0, 8'h45);
        hacc(1'b0, 2'd0, 8'h67);
        check(ch_addr == 21'h034567, "R3 port1 clear", ch_addr, 21'h034567);
        hacc(1'b0, 2'd0, 8'h15);
        check(ch_addr == 21'h154567, "R3 wrap to MSB", ch_addr, 21'h154567);

        // R4 / R8 / R6 writes with stall sweep
        for (int s = 0; s < 7; s++) begin
            stall_cfg = s;
            a = (s == 6) ? 21'h1FFFFE : 21'(32'h0F000 + s * 32'h1111);
            set_addr(a);
            c0 = cyc_n;
            hacc(1'b0, 2'd2, 8'(8'hA0 + s));
            check(cyc_n == c0 && wcnt == 0, "R4 even write no cycle", cyc_n - c0, 0);
            hacc(1'b0, 2'd3, 8'(8'h30 + s));
            check(cyc_n == c0 + 1, "R4 one cycle", cyc_n - c0, 1);
            check(cap_data == {8'(8'hA0 + s), 8'(8'h30 + s)}, "R4 data", cap_data, {8'(8'hA0 + s), 8'(8'h30 + s)});
            check(cap_addr == a, "R4 addr", cap_addr, a);
            check(wcnt == 3 + ((s > 1) ? s - 1 : 0), "R6 wait length", wcnt, 3 + ((s > 1) ? s - 1 : 0));
            check(ch_addr == ((a + 21'd2) & AMASK), "R8 step", ch_addr, (a + 21'd2) & AMASK);
        end

        // R5 reads, streamed
        stall_cfg = 2;
        a = 21'h1A3B4C;
        set_addr(a);
        for (int k = 0; k < 4; k++) begin
            logic [20:0] ak;
            logic [15:0] w;
            ak = (a + 21'(2 * k)) & AMASK;
            w  = chassis_word(ak);
            c0 = cyc_n;
            hacc(1'b1, 2'd2, 8'h00);
            check(rdata == w[15:8], "R5 even read", rdata, w[15:8]);
            check(cyc_n == c0 + 1 && wcnt == 4, "R5/R6 read cycle", wcnt, 4);
            hacc(1'b1, 2'd3, 8'h00);
            check(rdata == w[7:0], "R5 odd latched", rdata, w[7:0]);
            check(cyc_n == c0 + 1 && wcnt == 0, "R5 odd no cycle", cyc_n - c0, 1);
            check(ch_addr == ((ak + 21'd2) & AMASK), "R8 read step", ch_addr, (ak + 21'd2) & AMASK);
        end

        // R9 unselected strobes ignored
        stall_cfg = 0;
        a = 21'h00ABC0;
        set_addr(a);
        c0 = cyc_n;
        @(negedge clk);
        sel = 1'b0; wr_stb = 1'b1; port = 2'd3; wdata = 8'h99;
        @(negedge clk);
        port = 2'd0;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
        check(cyc_n == c0 && !wait_o, "R9 unselected no cycle", cyc_n - c0, 0);
        check(ch_addr == a, "R9 unselected no load", ch_addr, a);

        // R9 strobes during busy ignored
        @(negedge clk);
        sel = 1'b1; wr_stb = 1'b1; port = 2'd3; wdata = 8'h42;
        @(negedge clk);
        port = 2'd0; wdata = 8'hFF;
        @(negedge clk);
        wr_stb = 1'b0;
        while (wait_o) @(negedge clk);
        check(cyc_n == c0 + 1, "R9 busy one cycle", cyc_n - c0, 1);
        check(ch_addr == a + 21'd2, "R9 busy no load", ch_addr, a + 21'd2);

        // R7 / R10 continuous monitor
        check(viol == 0, "R7/R10 strobe relations", viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule